// File: doc/BRIEF.md
# Autonomous Periodic Wakeup Timer

This block is a small always-on timer with a byte-wide register port. Once started, it counts down a programmable 16-bit reload value on ticks from one of two sources: the rising edges of a slow free-running low-power oscillator, or every cycle of the register (bus) clock. Each time the count runs out it sets a periodic flag, which can raise an interrupt. It can also drive a waveform on an external pin. The waveform is either a square clock that changes level once per period, or a one-tick high pulse at the end of each period.

The block also carries a low-voltage detector input. A two-stage synchronizer feeds that input into a read-only status bit. Any change of the status bit, rising or falling, sets a sticky low-voltage flag with its own interrupt enable. Software clears either flag by writing 1 to it. The clock source cannot be changed while the timer runs. This also applies to the write that starts the timer.

Top module: `periodic_wake_ctl`

## Requirements
- R1: After reset every register reads 0x00, and `pin_out`, `irq_tick` and `irq_lowv` are low.
- R2: The register map is as follows. Address 0 is control: bit0 run, bit1 source select, bit2 pin enable, bit3 pin mode, bit4 tick interrupt enable. Address 1 is status: bit0 tick flag, bit1 low-voltage flag, bit2 low-voltage status (read-only), bit3 low-voltage interrupt enable. Addresses 2 and 3 hold the reload value, low byte then high byte. Unused bits read 0.
- R3: Setting run loads the reload value R and starts counting. With the bus-clock source, the tick flag is first set R+1 clock edges after the edge that takes the write, and then every R+1 edges.
- R4: The source-select bit changes only on a control write made while run is 0 and the written run bit is 0. A write that sets run leaves the source select as it was.
- R5: Source select 0 counts synchronized rising edges of `lp_osc`, so the bus clock alone does not advance the count. Source select 1 counts every bus clock cycle.
- R6: With pin mode 1, `pin_out` starts low and inverts at each expiry, so one full cycle spans two periods.
- R7: With pin mode 0, `pin_out` goes high at each expiry for one tick, which is half of the two-tick minimum period (reload ≥ 1).
- R8: `pin_out` stays low unless both run and pin enable are 1.
- R9: The low-voltage status bit follows `lv_det` through two synchronizer stages. The low-voltage flag is set on every change of that status bit, in either direction.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it set. If a set event and a clear arrive in the same cycle, the set wins.
- R11: `irq_tick` equals the tick flag ANDed with the tick interrupt enable. `irq_lowv` equals the low-voltage flag ANDed with the low-voltage interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register/bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| lp_osc | input | 1 | Low-power oscillator, asynchronous |
| lv_det | input | 1 | Low-voltage detector level, asynchronous |
| pin_out | output | 1 | External waveform pin |
| irq_tick | output | 1 | Periodic interrupt request |
| irq_lowv | output | 1 | Low-voltage interrupt request |

## Verification
Some behaviours are checked by the in-line assertions on every cycle:
- The source select stays fixed while running and in the write that starts the timer.
- An expiry sets the tick flag on the next edge.
- A status change sets the low-voltage flag.
- A zero written to a set flag leaves it set.
- The pin inverts at each expiry in clock mode.

Other behaviours only the bench scenarios can show:
- The exact edge on which the first expiry lands.
- The one-tick pulse width.
- That the bus clock alone does not advance the count in oscillator mode.
- That the pin stays silent when pin enable is 0.
- The register readback values.

// File: rtl/pwt_pkg.sv
// Package: shared register addresses and field positions for the wakeup timer.
// Assumes: byte-wide register port; reload bytes follow the status register.
package pwt_pkg;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_RLD0 = 2;

    // control register fields
    localparam int C_RUN   = 0;
    localparam int C_CSEL  = 1;
    localparam int C_PINEN = 2;
    localparam int C_PMODE = 3;
    localparam int C_TIE   = 4;

    // status register fields
    localparam int S_TFLG  = 0;
    localparam int S_LFLG  = 1;
    localparam int S_LSTAT = 2;
    localparam int S_LIE   = 3;

    typedef struct packed {
        logic tick_ie;
        logic pin_mode;
        logic pin_en;
        logic clk_sel;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/pwt_sync.sv
// Module: multi-stage flip-flop synchronizer for asynchronous levels.
// Assumes: inputs are slow levels relative to clk; reset value 0.
module pwt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // one stage of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= '0;
                else if (s == 0) chain[s] <= d_async;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwt_counter.sv
// Module: period down-counter and pin waveform generator.
// Assumes: lp_lvl is already synchronized; reload >= 1 for pulse mode to be
// distinguishable from a steady level.
module pwt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clk_sel,
    input  logic             pin_mode,
    input  logic             lp_lvl,
    input  logic [CNT_W-1:0] reload,
    output logic             expire,
    output logic             wave
);
    logic             lp_prev;
    logic             tick;
    logic [CNT_W-1:0] cnt;

    // remember last oscillator level for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lp_prev <= 1'b0;
        else        lp_prev <= lp_lvl;
    end

    assign tick   = clk_sel ? 1'b1 : (lp_lvl & ~lp_prev);
    assign expire = run & tick & (cnt == '0);

    // down-counter: tracks reload while stopped, reloads on expiry
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= reload;
        else if (tick)  cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end

    // waveform: toggle per expiry, or one-tick pulse at expiry
    always_ff @(posedge clk) begin
        if (!rst_n)                 wave <= 1'b0;
        else if (!run)              wave <= 1'b0;
        else if (expire)            wave <= pin_mode ? ~wave : 1'b1;
        else if (tick && !pin_mode) wave <= 1'b0;
    end

    // R7
    pulse_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wave && run && !pin_mode && tick && !expire) |=> !wave);
endmodule

// File: rtl/pwt_regs.sv
// Module: control/status/reload registers with write-protect and W1C flags.
// Assumes: lv_lvl is already synchronized; rdata is combinational on addr.
module pwt_regs
    import pwt_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int NB   = CNT_W / 8,
    localparam int AW   = $clog2(ADDR_RLD0 + NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             lv_lvl,
    input  logic             expire,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             tick_flag,
    output logic             lv_flag,
    output logic             lv_ie
);
    logic wr_ctrl, wr_stat;
    logic lv_prev, lv_chg;

    assign wr_ctrl = wr_en && (addr == AW'(ADDR_CTRL));
    assign wr_stat = wr_en && (addr == AW'(ADDR_STAT));
    assign lv_chg  = lv_lvl ^ lv_prev;

    // control fields; source select guarded by run state and written run bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.run      <= wdata[C_RUN];
            ctrl.pin_en   <= wdata[C_PINEN];
            ctrl.pin_mode <= wdata[C_PMODE];
            ctrl.tick_ie  <= wdata[C_TIE];
            if (!ctrl.run && !wdata[C_RUN]) ctrl.clk_sel <= wdata[C_CSEL];
        end
    end

    // low-voltage status history for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) lv_prev <= 1'b0;
        else        lv_prev <= lv_lvl;
    end

    // status: sticky flags (set wins over write-1-clear) and lv enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_flag <= 1'b0;
            lv_flag   <= 1'b0;
            lv_ie     <= 1'b0;
        end else begin
            if (expire)                        tick_flag <= 1'b1;
            else if (wr_stat && wdata[S_TFLG]) tick_flag <= 1'b0;
            if (lv_chg)                        lv_flag <= 1'b1;
            else if (wr_stat && wdata[S_LFLG]) lv_flag <= 1'b0;
            if (wr_stat)                       lv_ie <= wdata[S_LIE];
        end
    end

    generate
        for (genvar b = 0; b < NB; b++) begin : g_rld
            // one reload byte lane
            always_ff @(posedge clk) begin
                if (!rst_n)
                    reload[8*b +: 8] <= 8'h00;
                else if (wr_en && (addr == AW'(ADDR_RLD0 + b)))
                    reload[8*b +: 8] <= wdata;
            end
        end
    endgenerate

    // read multiplexer
    always_comb begin
        rdata = 8'h00;
        if (addr == AW'(ADDR_CTRL))
            rdata = {3'b000, ctrl.tick_ie, ctrl.pin_mode, ctrl.pin_en,
                     ctrl.clk_sel, ctrl.run};
        else if (addr == AW'(ADDR_STAT))
            rdata = {4'b0000, lv_ie, lv_lvl, lv_flag, tick_flag};
        for (int b = 0; b < NB; b++)
            if (addr == AW'(ADDR_RLD0 + b)) rdata = reload[8*b +: 8];
    end

    // R4
    clksel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run || (wr_ctrl && wdata[C_RUN])) |=> $stable(ctrl.clk_sel));
    // R3
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tick_flag);
    // R9
    lv_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_lvl != $past(lv_lvl)) |=> lv_flag);
    // R10
    w1c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_flag && wr_stat && !wdata[S_LFLG]) |=> lv_flag);
endmodule

// File: rtl/periodic_wake_ctl.sv
// Module: top of the autonomous periodic wakeup timer.
// Assumes: lp_osc and lv_det are asynchronous levels; single clock domain clk.
module periodic_wake_ctl #(
    parameter int  CNT_W = 16,
    localparam int NB    = CNT_W / 8,
    localparam int AW    = $clog2(pwt_pkg::ADDR_RLD0 + NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          lp_osc,
    input  logic          lv_det,
    output logic          pin_out,
    output logic          irq_tick,
    output logic          irq_lowv
);
    pwt_pkg::ctrl_t   ctrl;
    logic [CNT_W-1:0] reload;
    logic             tick_flag, lv_flag, lv_ie;
    logic             expire, wave;
    logic [1:0]       sync_q;

    pwt_sync #(.W(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({lv_det, lp_osc}), .q_sync(sync_q)
    );

    pwt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lv_lvl(sync_q[1]),
        .expire(expire), .ctrl(ctrl), .reload(reload),
        .tick_flag(tick_flag), .lv_flag(lv_flag), .lv_ie(lv_ie)
    );

    pwt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .clk_sel(ctrl.clk_sel),
        .pin_mode(ctrl.pin_mode), .lp_lvl(sync_q[0]), .reload(reload),
        .expire(expire), .wave(wave)
    );

    assign pin_out  = wave & ctrl.run & ctrl.pin_en;
    assign irq_tick = tick_flag & ctrl.tick_ie;
    assign irq_lowv = lv_flag & lv_ie;

    // R6
    pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run && ctrl.pin_en && ctrl.pin_mode && expire && !wr_en)
        |=> (pin_out != $past(pin_out)));
endmodule

// File: tb/sim_periodic_wake_ctl.sv
module sim_periodic_wake_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       lp_osc = 1'b0;
    logic       lv_det = 1'b0;
    logic       pin_out, irq_tick, irq_lowv;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    periodic_wake_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lp_osc(lp_osc), .lv_det(lv_det),
        .pin_out(pin_out), .irq_tick(irq_tick), .irq_lowv(irq_lowv)
    );

    // {addr, write data, expected readback of same address}
    localparam logic [23:0] VEC [0:12] = '{
        {8'd0, 8'h02, 8'h02},   // R4 select written while stopped
        {8'd0, 8'h00, 8'h00},
        {8'd0, 8'h03, 8'h01},   // R4 same-write start keeps select 0
        {8'd0, 8'h03, 8'h01},   // R4 running, select locked
        {8'd0, 8'h00, 8'h00},
        {8'd0, 8'h02, 8'h02},
        {8'd0, 8'h01, 8'h03},   // R4 select 1 survives start
        {8'd0, 8'h00, 8'h02},   // R4 stop write still locked
        {8'd0, 8'h00, 8'h00},
        {8'd2, 8'h34, 8'h34},   // R2 reload low byte
        {8'd3, 8'h12, 8'h12},   // R2 reload high byte
        {8'd1, 8'h09, 8'h08},   // R10 clear tick flag, set lv enable
        {8'd0, 8'h10, 8'h10}    // R2 tick enable field
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic       bad;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reg", v, 8'h00);
        end
        chk("R1 pins", {5'd0, pin_out, irq_tick, irq_lowv}, 8'h00);

        // R2 R4 vector table
        for (int i = 0; i < 13; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16], v);
            chk("R2/R4 table", v, VEC[i][7:0]);
        end

        // R3 period with bus clock, reload 4
        wr(2'd2, 8'h04); wr(2'd3, 8'h00); wr(2'd1, 8'h09);
        wr(2'd0, 8'h02);
        wr(2'd0, 8'h13);
        cyc(4);
        chk("R3 before expiry", {7'd0, irq_tick}, 8'h00);
        cyc(1);
        chk("R3 R11 at expiry", {7'd0, irq_tick}, 8'h01);
        // R10 writing 0 keeps flag
        wr(2'd1, 8'h08);
        rd(2'd1, v);
        chk("R10 write zero", v[0] ? 8'h01 : 8'h00, 8'h01);
        wr(2'd0, 8'h02); wr(2'd1, 8'h09);
        rd(2'd1, v);
        chk("R10 write one clears", v, 8'h08);

        // R6 clock mode
        wr(2'd0, 8'h0F);
        cyc(4);  chk("R6 k4", {7'd0, pin_out}, 8'h00);
        cyc(1);  chk("R6 k5", {7'd0, pin_out}, 8'h01);
        cyc(4);  chk("R6 k9", {7'd0, pin_out}, 8'h01);
        cyc(1);  chk("R6 k10", {7'd0, pin_out}, 8'h00);
        wr(2'd0, 8'h02);

        // R7 pulse mode
        wr(2'd0, 8'h07);
        cyc(4);  chk("R7 k4", {7'd0, pin_out}, 8'h00);
        cyc(1);  chk("R7 k5", {7'd0, pin_out}, 8'h01);
        cyc(1);  chk("R7 k6", {7'd0, pin_out}, 8'h00);
        cyc(4);  chk("R7 k10", {7'd0, pin_out}, 8'h01);
        wr(2'd0, 8'h02);

        // R8 pin disabled while running
        wr(2'd0, 8'h03);
        bad = 1'b0;
        for (int k = 0; k < 12; k++) begin
            cyc(1);
            if (pin_out) bad = 1'b1;
        end
        chk("R8 pin held low", {7'd0, bad}, 8'h00);
        wr(2'd0, 8'h02); wr(2'd0, 8'h00); wr(2'd1, 8'h09);
        rd(2'd0, v);
        chk("R4 select back to 0", v, 8'h00);

        // R5 low-power oscillator source, reload 1 -> two ticks
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h01);
        cyc(20);
        rd(2'd1, v);
        chk("R5 no bus-clock counting", v, 8'h08);
        lp_osc = 1'b1; cyc(4); lp_osc = 1'b0; cyc(4);
        rd(2'd1, v);
        chk("R5 one tick", v, 8'h08);
        lp_osc = 1'b1; cyc(4); lp_osc = 1'b0; cyc(6);
        rd(2'd1, v);
        chk("R5 two ticks expire", v, 8'h09);
        wr(2'd0, 8'h00); wr(2'd1, 8'h09);

        // R9 low-voltage rising change
        lv_det = 1'b1;
        cyc(5);
        rd(2'd1, v);
        chk("R9 rise", v, 8'h0E);
        chk("R11 lv irq", {7'd0, irq_lowv}, 8'h01);
        wr(2'd1, 8'h08);
        rd(2'd1, v);
        chk("R10 lv write zero", v, 8'h0E);
        wr(2'd1, 8'h0A);
        rd(2'd1, v);
        chk("R10 lv clear", v, 8'h0C);
        chk("R11 lv irq low", {7'd0, irq_lowv}, 8'h00);
        // R9 falling change
        lv_det = 1'b0;
        cyc(5);
        rd(2'd1, v);
        chk("R9 fall", v, 8'h0A);
        wr(2'd1, 8'h02);
        chk("R11 lv masked", {7'd0, irq_lowv}, 8'h00);

        finish_run();
    end
endmodule